// File: doc/BRIEF.md
# Command Slot Issue Port

This block is a small command queue that sits behind a word-wide slave bus. It holds a fixed number of slots. Each slot is a 32-bit command word paired with a 32-bit data word. A host can reach the slots in two ways. The first is a plain register image, where every command word and data word can be read and written directly. The second is an issue image, built so that one atomic read-modify-write both claims a free slot and files a command into it. On that image, the read half returns the index of the slot being claimed. The write half stores the bus data as the slot's data word, and builds the command fields from the access address.

On the other side, a consumer is shown the slot at the execute pointer whenever that slot holds a valid command. Slots are drained strictly in round-robin order, so commands leave in the order they were filed. The consumer signals completion with a done strobe. That strobe clears the full bit, marks the slot finished, records an error flag, and can optionally replace the data word with a result.

Command word layout: bit 31 is full, bit 30 is finished, bit 29 is error, and bits 28 to 15 read as zero. Bits 14 to 9 hold the command type and bits 8 to 0 hold an immediate. Bus addresses are byte addresses. Address bit 18 selects the issue image (1) or the register image (0). In the register image, address bit 2 picks the data word (1) or the command word (0), and bits from 3 upward pick the slot.

Top module: `cmd_slot_port`

## Requirements
- R1: After reset every slot reads zero, both pointers are at slot 0, bus_ack is low and cmd_valid is low.
- R2: A register-image write with address bit 2 clear stores bus_wdata as the command word of the slot selected by the address bits from 3 upward. With bit 2 set, it stores bus_wdata as that slot's data word. A register-image read returns the selected word.
- R3: A read of the issue image returns the free pointer, zero-extended, when the slot it names is not full. When that slot is full, the read returns 32'hFFFF_FFFF.
- R4: An issue-image write to a free slot does four things. It stores bus_wdata as the slot's data word. It writes the command word with full set, finished and error clear, bits 28 to 15 zero, and bits 14 to 0 equal to address bits 17 to 3. It then advances the free pointer, wrapping from DEPTH-1 to 0.
- R5: An issue-image write when the slot at the free pointer is full is still acknowledged, but it changes no slot and no pointer.
- R6: In a read-modify-write on the issue image, the read data reflects the slot state before the access. That value is the index of the slot the write fills, or all ones if the write is dropped.
- R7: An issue-image write whose command type (address bits 17 to 12) is zero is acknowledged, but it changes no slot and no pointer.
- R8: cmd_valid is high exactly when the slot at the execute pointer is full and has a nonzero type. cmd_slot, cmd_word and cmd_data show that slot. After each completion, the execute pointer moves to the next slot modulo DEPTH.
- R9: When cmd_done is high while cmd_valid is high, the presented slot's full bit clears, finished sets, and error takes done_err. If done_has_result is high, the data word becomes done_result; otherwise it is kept.
- R10: A full slot at the execute pointer with command type zero is never presented. On the next edge it is retired with full clear and both finished and error set, and the execute pointer advances.
- R11: bus_ack is high in the cycle after each cycle with bus_req high, and low otherwise. The read data is valid alongside bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | Write access |
| bus_rmw | input | 1 | Atomic read-modify-write access |
| bus_addr | input | AW (20) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| cmd_valid | output | 1 | A command is presented to the consumer |
| cmd_slot | output | IW (2) | Index of the presented slot |
| cmd_word | output | 32 | Command word of the presented slot |
| cmd_data | output | 32 | Data word of the presented slot |
| cmd_done | input | 1 | Consumer completes the presented command |
| done_has_result | input | 1 | Replace the data word with done_result |
| done_err | input | 1 | Completion error flag |
| done_result | input | 32 | Result data |

## Verification
A wrong free pointer shows up at the very next issue-image read. That read returns a stale index or all ones. It also shows up in the register-image readback of the slot that was expected to fill. A wrong execute pointer shows within one cycle: cmd_slot and cmd_word name a slot other than the oldest filed one, and the break in order is visible across a pointer wrap. A lost or misapplied completion is visible as soon as the slot's command word is read back through the register image, in the finished, error and full bits and in the data word.

// File: rtl/cmd_slot_port.sv
module cmd_slot_port #(
  parameter int DEPTH = 4,
  parameter int AW    = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                bus_req,
  input  logic                                bus_we,
  input  logic                                bus_rmw,
  input  logic [AW-1:0]                       bus_addr,
  input  logic [31:0]                         bus_wdata,
  output logic                                bus_ack,
  output logic [31:0]                         bus_rdata,
  output logic                                cmd_valid,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] cmd_slot,
  output logic [31:0]                         cmd_word,
  output logic [31:0]                         cmd_data,
  input  logic                                cmd_done,
  input  logic                                done_has_result,
  input  logic                                done_err,
  input  logic [31:0]                         done_result
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [31:0] cmd_q [DEPTH];
  logic [31:0] dat_q [DEPTH];
  logic [IW-1:0] free_ptr, exe_ptr;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic          issue_sel, word_sel, slot_ok, is_wr, is_rd;
  logic [IW-1:0] reg_slot;
  logic          free_full, type_ok, issue_wr, reg_wr;
  logic          exe_full, exe_t0, complete, retire;
  logic [31:0]   reg_val, issue_val;

  assign issue_sel = bus_addr[18];
  assign word_sel  = bus_addr[2];
  assign reg_slot  = bus_addr[3 +: IW];
  assign slot_ok   = (32'(reg_slot) < DEPTH);
  assign is_wr     = bus_req & (bus_we | bus_rmw);
  assign is_rd     = bus_req & (~bus_we | bus_rmw);

  assign free_full = cmd_q[free_ptr][31];
  assign type_ok   = (bus_addr[17:12] != 6'd0);
  assign issue_wr  = is_wr & issue_sel & ~free_full & type_ok;
  assign reg_wr    = is_wr & ~issue_sel & slot_ok;

  assign exe_full  = cmd_q[exe_ptr][31];
  assign exe_t0    = (cmd_q[exe_ptr][14:9] == 6'd0);
  assign cmd_valid = exe_full & ~exe_t0;
  assign complete  = cmd_done & cmd_valid;
  assign retire    = exe_full & exe_t0;

  assign cmd_slot  = exe_ptr;
  assign cmd_word  = cmd_q[exe_ptr];
  assign cmd_data  = dat_q[exe_ptr];

  assign issue_val = free_full ? '1 : 32'(free_ptr);
  assign reg_val   = !slot_ok ? '0 : (word_sel ? dat_q[reg_slot] : cmd_q[reg_slot]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cmd_q[i] <= '0;
        dat_q[i] <= '0;
      end
      free_ptr  <= '0;
      exe_ptr   <= '0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (reg_wr && reg_slot == IW'(i)) begin
          if (word_sel) dat_q[i] <= bus_wdata;
          else          cmd_q[i] <= bus_wdata;
        end
        if (issue_wr && free_ptr == IW'(i)) begin
          cmd_q[i] <= {1'b1, 2'b00, 14'd0, bus_addr[17:3]};
          dat_q[i] <= bus_wdata;
        end
        if ((complete || retire) && exe_ptr == IW'(i)) begin
          cmd_q[i][31] <= 1'b0;
          cmd_q[i][30] <= 1'b1;
          cmd_q[i][29] <= retire | done_err;
          if (complete && done_has_result) dat_q[i] <= done_result;
        end
      end
      if (issue_wr)            free_ptr <= step(free_ptr);
      if (complete || retire)  exe_ptr  <= step(exe_ptr);
      bus_ack   <= bus_req;
      bus_rdata <= is_rd ? (issue_sel ? issue_val : reg_val) : '0;
    end
  end
endmodule

// File: rtl/cmd_slot_port_chk.sv
module cmd_slot_port_chk #(
  parameter int DEPTH = 4,
  parameter int IW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          cmd_valid,
  input logic          cmd_done,
  input logic [IW-1:0] cmd_slot,
  input logic [31:0]   cmd_word
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  p_ack_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  p_no_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
  p_valid_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_word[31]);
  p_no_type0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_word[14:9] != 6'd0));
  p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_done) |=>
      (cmd_slot == (($past(cmd_slot) == LAST) ? '0 : $past(cmd_slot) + 1'b1)));
endmodule

bind cmd_slot_port cmd_slot_port_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .cmd_valid(cmd_valid), .cmd_done(cmd_done), .cmd_slot(cmd_slot),
  .cmd_word(cmd_word)
);

// File: tb/cmd_slot_port_bench.sv
module cmd_slot_port_bench;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_rmw = 0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack;
  logic [31:0] bus_rdata;
  logic cmd_valid;
  logic [1:0] cmd_slot;
  logic [31:0] cmd_word, cmd_data;
  logic cmd_done = 0, done_has_result = 0, done_err = 0;
  logic [31:0] done_result = '0;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  cmd_slot_port u_cmd_slot_port (.*);

  // op(2) chk(1) addr(20) wdata(32) exp(32); op 0 read, 1 write, 2 rmw
  localparam int NV = 17;
  localparam logic [86:0] VEC [NV] = '{
    {2'd0, 1'b1, 20'h40000, 32'h0,        32'h0},          // R3
    {2'd0, 1'b1, 20'h00000, 32'h0,        32'h0},          // R1
    {2'd2, 1'b1, 20'h45090, 32'hAAAA0001, 32'h0},          // R6
    {2'd0, 1'b1, 20'h00000, 32'h0,        32'h80000A12},   // R4
    {2'd0, 1'b1, 20'h00004, 32'h0,        32'hAAAA0001},   // R4
    {2'd1, 1'b0, 20'h43008, 32'hBBBB0002, 32'h0},
    {2'd0, 1'b1, 20'h40000, 32'h0,        32'h2},          // R3
    {2'd1, 1'b0, 20'h40008, 32'h0000DEAD, 32'h0},          // R7
    {2'd0, 1'b1, 20'h40000, 32'h0,        32'h2},          // R7
    {2'd2, 1'b1, 20'h7FFF8, 32'hCCCC0003, 32'h2},          // R6
    {2'd2, 1'b1, 20'h41008, 32'hDDDD0004, 32'h3},          // R6
    {2'd0, 1'b1, 20'h40000, 32'h0,        32'hFFFFFFFF},   // R3
    {2'd2, 1'b1, 20'h41010, 32'h12345678, 32'hFFFFFFFF},   // R5
    {2'd0, 1'b1, 20'h00004, 32'h0,        32'hAAAA0001},   // R5
    {2'd0, 1'b1, 20'h00010, 32'h0,        32'h80007FFF},   // R4
    {2'd0, 1'b1, 20'h00018, 32'h0,        32'h80000201},   // R4
    {2'd0, 1'b1, 20'h0000C, 32'h0,        32'hBBBB0002}    // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] op, input logic [19:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_we = (op == 2'd1); bus_rmw = (op == 2'd2);
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_rmw = 0;
    check("R11 ack", 32'(bus_ack), 32'h1);
    r = bus_rdata;
  endtask

  task automatic done_pulse(input logic res, input logic err, input logic [31:0] v);
    @(negedge clk);
    cmd_done = 1; done_has_result = res; done_err = err; done_result = v;
    @(negedge clk);
    cmd_done = 0; done_has_result = 0; done_err = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ack", 32'(bus_ack), 32'h0);
    check("R1 valid", 32'(cmd_valid), 32'h0);
    check("R1 slot", 32'(cmd_slot), 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][86:85], VEC[i][83:64], VEC[i][63:32], r);
      if (VEC[i][84]) check($sformatf("vec%0d", i), r, VEC[i][31:0]);
    end

    check("R8 valid", 32'(cmd_valid), 32'h1);
    check("R8 slot", 32'(cmd_slot), 32'h0);
    check("R8 word", cmd_word, 32'h80000A12);
    check("R8 data", cmd_data, 32'hAAAA0001);

    done_pulse(1, 0, 32'h55);
    bus_op(0, 20'h00000, 0, r); check("R9 cmd0", r, 32'h40000A12);
    bus_op(0, 20'h00004, 0, r); check("R9 result", r, 32'h55);
    check("R8 next slot", 32'(cmd_slot), 32'h1);
    check("R8 next word", cmd_word, 32'h80000601);

    done_pulse(0, 1, 32'hFFFF);
    bus_op(0, 20'h00008, 0, r); check("R9 err", r, 32'h60000601);
    bus_op(0, 20'h0000C, 0, r); check("R9 keep", r, 32'hBBBB0002);

    bus_op(0, 20'h40000, 0, r); check("R4 wrap free", r, 32'h0);
    bus_op(1, 20'h42000, 32'h7, r);
    bus_op(0, 20'h40000, 0, r); check("R4 advance", r, 32'h1);

    done_pulse(0, 0, 0);
    done_pulse(0, 0, 0);
    check("R8 wrap slot", 32'(cmd_slot), 32'h0);
    check("R8 wrap word", cmd_word, 32'h80000400);
    check("R8 wrap data", cmd_data, 32'h7);

    done_pulse(1, 0, 32'h99);
    bus_op(1, 20'h00008, 32'h80000000, r);
    check("R10 not shown", 32'(cmd_valid), 32'h0);
    @(negedge clk);
    bus_op(0, 20'h00008, 0, r); check("R10 retired", r, 32'h60000000);
    check("R10 advance", 32'(cmd_slot), 32'h2);

    bus_op(1, 20'h0001C, 32'h9, r);
    bus_op(0, 20'h0001C, 0, r); check("R2 data rw", r, 32'h9);
    bus_op(1, 20'h00018, 32'h00000123, r);
    bus_op(0, 20'h00018, 0, r); check("R2 cmd rw", r, 32'h00000123);

    @(negedge clk);
    check("R11 idle", 32'(bus_ack), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule